// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block is an 8N1 serial transceiver that can share one data wire with other nodes. In half-duplex mode the transmitter controls the direction of its own pad. The pad driver is switched on only for the window around each frame and released at all other times. The receiver listens to the transmit node rather than to a separate receive pin, so every byte sent comes back as a received byte, and software has to discard that echo. A driver-enable output mirrors the pad driver enable, so an external RS485-style transceiver can follow it. Two programmable windows, lead and lag, keep the wire actively driven high for a few oversampling ticks before the start bit and after the stop bit.

Software starts a frame by writing a byte on the parallel write port. The transmitter does not check whether another node is driving the wire; arbitration is left to higher layers. When the transmitter is first enabled, it sends one quiet idle frame, during which neither the pad nor the driver-enable output is active. When half-duplex mode is off, the block behaves as an ordinary two-wire UART: the pad is always driven and the receiver uses the dedicated input.

Top module: `hdx_uart`

## Requirements
- R1: With `cfg_half_duplex`=1, the receiver input is the transmit node: it is `pad_out` while `pad_oe`=1 and `pad_in` otherwise. Every transmitted byte is therefore received back with no framing error, and `rx_in` has no effect.
- R2: With `cfg_half_duplex`=1, `pad_oe` is 1 only from the cycle after an accepted write until the lag window ends. At all other times it is 0, including after reset.
- R3: `de` is 1 exactly while a frame window (lead, start, data, stop, lag) is in progress. In half-duplex mode `pad_oe` equals `de` on every cycle.
- R4: A write (`wr_en`=1) is accepted only when `cfg_tx_enable`=1 and the transmitter is idle, and `de` rises on the next cycle with no check of the line. Writes made during a frame, during the idle frame, or while the transmitter is disabled are ignored.
- R5: Before the start bit, the line is driven high (`de`=1, `pad_out`=1) for `cfg_lead_ticks` ticks. The maximum value of 31 is one tick short of two bit periods.
- R6: After the stop bit, the line stays driven high for `cfg_lag_ticks` ticks before `de` falls. The total `de` high time is (lead + 160 + lag) × (`cfg_baud_div`+1) clock cycles.
- R7: A rising edge of `cfg_tx_enable` starts an idle frame of 160 ticks. During it `de`=0, `pad_out`=1, and in half-duplex mode `pad_oe`=0.
- R8: A tick lasts `cfg_baud_div`+1 clock cycles, and a bit lasts 16 ticks. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit.
- R9: The receiver takes a 2-of-3 majority of the line at ticks 7, 8 and 9 of each bit. When it finishes the stop-bit sample, it presents the byte on `rx_data` with a one-cycle `rx_valid` pulse.
- R10: `rx_frame_err` pulses together with `rx_valid` when the stop-bit sample is low. The receiver then waits for the line to go high before it looks for a new start bit. A line held low continuously is therefore reported as byte 0x00 with a framing error, not as repeated frames.
- R11: With `cfg_half_duplex`=0, `pad_oe` stays 1 and `pad_out` idles high. The receiver uses `rx_in`, and transmitted bytes are not echoed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_duplex | input | 1 | 1 selects single-wire mode |
| cfg_tx_enable | input | 1 | Transmitter enable; a rising edge sends the idle frame |
| cfg_baud_div | input | DIV_W | Tick period minus one, in clock cycles |
| cfg_lead_ticks | input | TIME_W | Drive-high ticks before the start bit |
| cfg_lag_ticks | input | TIME_W | Drive-high ticks after the stop bit |
| wr_en | input | 1 | Write strobe for transmit data |
| wr_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is received |
| rx_frame_err | output | 1 | Stop bit was low; pulses with `rx_valid` |
| pad_out | output | 1 | Transmit pad output value |
| pad_oe | output | 1 | Transmit pad output enable |
| pad_in | input | 1 | Value read back from the transmit pad |
| rx_in | input | 1 | Dedicated receive input (two-wire mode) |
| de | output | 1 | External transceiver driver enable |

## Verification
Some behaviours hold cycle by cycle and are checked by the assertions. Outside a frame window in half-duplex mode the pad is released, and it is always driven in two-wire mode. `de` only rises after an accepted write. The idle frame never drives. The line only goes low inside a frame window. `rx_valid` is a single-cycle pulse, a framing error appears only with it, and after an error the receiver always waits for a high line. Other behaviours need the bench scenarios: the exact lead, lag and frame durations; the echo contents under several byte patterns; writes dropped while busy, while disabled or during the idle frame; `rx_in` being ignored in single-wire mode; and the single error report for a wire that floats low.

// File: rtl/hdx_uart_pkg.sv
package hdx_uart_pkg;
  localparam int OVS             = 16;
  localparam int DBITS           = 8;
  localparam int IDLE_FRAME_BITS = 10;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_STOP, TX_LAG, TX_QUIET
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/hdx_tick_gen.sv
module hdx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt >= div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt >= div) && !restart;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick) else $error("tick spacing"); // R8
endmodule

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx
  import hdx_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DBITS-1:0]  wr_data,
  input  logic [DIV_W-1:0]  div,
  input  logic [TIME_W-1:0] lead,
  input  logic [TIME_W-1:0] lag,
  output logic              line_out,
  output logic              drive
);
  localparam int QUIET_TICKS = OVS * IDLE_FRAME_BITS;
  localparam int CNT_W       = $clog2(QUIET_TICKS + 1);
  localparam int BIT_W       = $clog2(DBITS);

  tx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [BIT_W-1:0] bit_idx;
  logic [DBITS-1:0] shreg;
  logic             en_q;
  logic             restart;
  logic             tick;
  logic             quiet_req;
  logic             start_req;

  assign quiet_req = (state == TX_IDLE) && tx_en && !en_q;
  assign start_req = (state == TX_IDLE) && tx_en && en_q && wr_en;
  assign restart   = quiet_req || start_req;
  assign cnt_nxt   = cnt + 1'b1;

  hdx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .div     (div),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '1;
      en_q    <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (state == TX_IDLE) begin
        if (quiet_req) begin
          state <= TX_QUIET;
          cnt   <= '0;
        end else if (start_req) begin
          shreg   <= wr_data;
          cnt     <= '0;
          bit_idx <= '0;
          state   <= (lead == '0) ? TX_START : TX_LEAD;
        end
      end else if (tick) begin
        cnt <= cnt_nxt;
        case (state)
          TX_LEAD: if (cnt_nxt == CNT_W'(lead)) begin
            state <= TX_START;
            cnt   <= '0;
          end
          TX_START: if (cnt_nxt == CNT_W'(OVS)) begin
            state <= TX_DATA;
            cnt   <= '0;
          end
          TX_DATA: if (cnt_nxt == CNT_W'(OVS)) begin
            cnt     <= '0;
            shreg   <= {1'b1, shreg[DBITS-1:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == BIT_W'(DBITS - 1)) state <= TX_STOP;
          end
          TX_STOP: if (cnt_nxt == CNT_W'(OVS)) begin
            cnt   <= '0;
            state <= (lag == '0) ? TX_IDLE : TX_LAG;
          end
          TX_LAG: if (cnt_nxt == CNT_W'(lag)) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end
          TX_QUIET: if (cnt_nxt == CNT_W'(QUIET_TICKS)) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      TX_START: line_out = 1'b0;
      TX_DATA:  line_out = shreg[0];
      default:  line_out = 1'b1;
    endcase
  end

  assign drive = (state == TX_LEAD) || (state == TX_START) || (state == TX_DATA) ||
                 (state == TX_STOP) || (state == TX_LAG);

  AST_DRIVE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> $past(wr_en)) else $error("drive without write"); // R4
  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && tx_en && en_q && wr_en) |=> drive) else $error("write not started"); // R4
  AST_LOW_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !line_out |-> drive) else $error("low outside frame"); // R2
  AST_QUIET_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == TX_QUIET) |-> (!drive && line_out)) else $error("idle frame drives"); // R7
endmodule

// File: rtl/hdx_uart_rx.sv
module hdx_uart_rx
  import hdx_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [DIV_W-1:0] div,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err
);
  localparam int PH_W  = $clog2(OVS);
  localparam int BIT_W = $clog2(DBITS);
  localparam int MID_A = OVS / 2 - 1;
  localparam int MID_B = OVS / 2;
  localparam int MID_C = OVS / 2 + 1;

  rx_state_e        state;
  logic             sync1, line;
  logic [PH_W-1:0]  cnt;
  logic [BIT_W-1:0] bit_idx;
  logic [DBITS-1:0] shreg;
  logic [2:0]       smp;
  logic             tick;
  logic             restart;
  logic             bit_vote;
  logic             stop_vote;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      line  <= 1'b1;
    end else begin
      sync1 <= line_in;
      line  <= sync1;
    end
  end

  assign restart   = (state == RX_IDLE) && !line;
  assign bit_vote  = vote3(smp[0], smp[1], smp[2]);
  assign stop_vote = vote3(smp[0], smp[1], line);

  hdx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .div     (div),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RX_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      smp          <= '1;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      case (state)
        RX_IDLE: if (!line) begin
          state <= RX_START;
          cnt   <= '0;
        end
        RX_WAITHI: if (line) state <= RX_IDLE;
        default: if (tick) begin
          cnt <= (cnt == PH_W'(OVS - 1)) ? '0 : cnt + 1'b1;
          if (cnt == PH_W'(MID_A)) smp[0] <= line;
          if (cnt == PH_W'(MID_B)) smp[1] <= line;
          if (cnt == PH_W'(MID_C)) smp[2] <= line;
          case (state)
            RX_START: if (cnt == PH_W'(OVS - 1)) begin
              bit_idx <= '0;
              state   <= bit_vote ? RX_IDLE : RX_DATA;
            end
            RX_DATA: if (cnt == PH_W'(OVS - 1)) begin
              shreg   <= {bit_vote, shreg[DBITS-1:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == BIT_W'(DBITS - 1)) state <= RX_STOP;
            end
            RX_STOP: if (cnt == PH_W'(MID_C)) begin
              rx_valid     <= 1'b1;
              rx_data      <= shreg;
              rx_frame_err <= !stop_vote;
              cnt          <= '0;
              state        <= stop_vote ? RX_IDLE : RX_WAITHI;
            end
            default: state <= RX_IDLE;
          endcase
        end
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid) else $error("valid longer than one cycle"); // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> rx_valid) else $error("error without valid"); // R10
  AST_WAIT_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> (state == RX_WAITHI)) else $error("no wait after error"); // R10
endmodule

// File: rtl/hdx_uart.sv
module hdx_uart
  import hdx_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_half_duplex,
  input  logic              cfg_tx_enable,
  input  logic [DIV_W-1:0]  cfg_baud_div,
  input  logic [TIME_W-1:0] cfg_lead_ticks,
  input  logic [TIME_W-1:0] cfg_lag_ticks,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              pad_out,
  output logic              pad_oe,
  input  logic              pad_in,
  input  logic              rx_in,
  output logic              de
);
  logic tx_line;
  logic tx_drive;
  logic tx_node;
  logic rx_src;

  hdx_uart_tx #(.DIV_W(DIV_W), .TIME_W(TIME_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (cfg_tx_enable),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .div      (cfg_baud_div),
    .lead     (cfg_lead_ticks),
    .lag      (cfg_lag_ticks),
    .line_out (tx_line),
    .drive    (tx_drive)
  );

  assign pad_out = tx_line;
  assign de      = tx_drive;
  assign pad_oe  = cfg_half_duplex ? tx_drive : 1'b1;
  assign tx_node = pad_oe ? tx_line : pad_in;
  assign rx_src  = cfg_half_duplex ? tx_node : rx_in;

  hdx_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .line_in      (rx_src),
    .div          (cfg_baud_div),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
  );

  AST_HD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (cfg_half_duplex && !de) |-> !pad_oe) else $error("pad driven outside frame"); // R2
  AST_FD_ALWAYS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !cfg_half_duplex |-> pad_oe) else $error("pad released in two-wire mode"); // R11
endmodule

// File: tb/tb_hdx_uart.sv
`timescale 1ns/1ps
module tb_hdx_uart;
  localparam int DIV   = 3;
  localparam int TICK  = DIV + 1;
  localparam int BIT   = 16 * TICK;
  localparam int QUIET = 160 * TICK;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, hd, txen, wr_en, pull, rx_in;
  logic [15:0] div;
  logic [4:0]  lead, lag;
  logic [7:0]  wr_data;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_frame_err, pad_out, pad_oe, de;
  logic        pad_in;

  assign pad_in = pad_oe ? pad_out : pull;

  hdx_uart dut (
    .clk(clk), .rst(rst), .cfg_half_duplex(hd), .cfg_tx_enable(txen),
    .cfg_baud_div(div), .cfg_lead_ticks(lead), .cfg_lag_ticks(lag),
    .wr_en(wr_en), .wr_data(wr_data), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .rx_in(rx_in), .de(de)
  );

  int checks = 0;
  int errors = 0;
  int valid_seen = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every received byte (R1, R9, R10)
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      valid_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected rx item: actual %h expected none",
                 {rx_frame_err, rx_data});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({rx_frame_err, rx_data} !== e) begin
          errors++;
          $display("FAIL R9 rx item: actual %h expected %h", {rx_frame_err, rx_data}, e);
        end
      end
    end
  end

  // driver: one write, then measure the frame window
  task automatic run_frame(input logic [7:0] b, input bit echo, input int extra_at,
                           input int exp_de, input int exp_lead, input string tag);
    int de_cyc, lead_cyc, oe_bad, oe_low;
    bit seen_low;
    if (echo) exp_q.push_back({1'b0, b});
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    de_cyc = 0; lead_cyc = 0; oe_bad = 0; oe_low = 0; seen_low = 1'b0;
    while (de === 1'b1) begin
      if (!seen_low && pad_out === 1'b1) lead_cyc++;
      else seen_low = 1'b1;
      if (hd && pad_oe !== de) oe_bad++;
      if (pad_oe !== 1'b1) oe_low++;
      de_cyc++;
      @(negedge clk);
      wr_en = (de_cyc == extra_at);
      if (de_cyc == extra_at) wr_data = 8'h99;
    end
    wr_en = 1'b0;
    check(de_cyc == exp_de, tag, "de window cycles", de_cyc, exp_de);
    check(lead_cyc == exp_lead, tag, "lead high cycles", lead_cyc, exp_lead);
    if (hd) check(oe_bad == 0, "R3", "pad_oe differs from de", oe_bad, 0);
    else    check(oe_low == 0, "R11", "pad_oe low in two-wire mode", oe_low, 0);
    repeat (BIT) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_v);
    @(negedge clk); rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx_in = stop_v;
    repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt_a, cnt_b, vs;
    rst = 1'b1; hd = 1'b1; txen = 1'b0; div = 16'(DIV); lead = '0; lag = '0;
    wr_en = 1'b0; wr_data = '0; pull = 1'b1; rx_in = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pad_oe == 1'b0, "R2", "pad_oe after reset", pad_oe, 0);
    check(de == 1'b0, "R3", "de after reset", de, 0);
    check(rx_valid == 1'b0, "R9", "rx_valid after reset", rx_valid, 0);

    // R4: write while transmitter disabled is ignored
    wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); wr_en = 1'b0;
    cnt_a = 0;
    for (int i = 0; i < 2 * BIT; i++) begin
      if (de) cnt_a++;
      @(negedge clk);
    end
    check(cnt_a == 0, "R4", "de cycles after disabled write", cnt_a, 0);

    // R7: idle frame on enable, quiet line, write inside it ignored
    txen = 1'b1;
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < QUIET + 8; i++) begin
      @(negedge clk);
      wr_en = (i == 100);
      wr_data = 8'h22;
      if (de || pad_oe) cnt_a++;
      if (!pad_out) cnt_b++;
    end
    wr_en = 1'b0;
    check(cnt_a == 0, "R7", "driven cycles in idle frame", cnt_a, 0);
    check(cnt_b == 0, "R7", "low cycles in idle frame", cnt_b, 0);

    // R1 R8: echo, several byte patterns and windows (R5, R6)
    run_frame(8'h55, 1'b1, -1, QUIET, 0, "R8");
    lead = 5'd31; lag = 5'd31;
    run_frame(8'hA3, 1'b1, -1, (31 + 160 + 31) * TICK, 31 * TICK, "R5");
    check(31 * TICK < 2 * BIT, "R5", "max lead below two bits", 31 * TICK, 2 * BIT);
    lead = 5'd5; lag = 5'd0;
    run_frame(8'h00, 1'b1, -1, (5 + 160) * TICK, 5 * TICK, "R5");
    lead = 5'd0; lag = 5'd9;
    run_frame(8'hFF, 1'b1, -1, (160 + 9) * TICK, 0, "R6");

    // R4: second write during a frame is dropped
    lag = 5'd0;
    run_frame(8'h3C, 1'b1, 200, QUIET, 0, "R4");

    // R1: rx_in has no effect in single-wire mode
    vs = valid_seen;
    drive_rx(8'h5A, 1'b1);
    check(valid_seen == vs, "R1", "rx items from rx_in in single-wire mode", valid_seen - vs, 0);

    // R10: wire floating low gives one 0x00 with framing error
    exp_q.push_back({1'b1, 8'h00});
    vs = valid_seen;
    pull = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    pull = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(valid_seen - vs == 1, "R10", "reports for low wire", valid_seen - vs, 1);

    // R11: two-wire mode
    hd = 1'b0;
    @(negedge clk);
    check(pad_oe == 1'b1 && pad_out == 1'b1, "R11", "idle pad drive", {pad_oe, pad_out}, 3);
    run_frame(8'h3C, 1'b0, -1, QUIET, 0, "R11");
    exp_q.push_back({1'b0, 8'hC5});
    drive_rx(8'hC5, 1'b1);
    exp_q.push_back({1'b1, 8'h96});
    drive_rx(8'h96, 1'b0);
    check(exp_q.size() == 0, "R10", "items left in scoreboard", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule